// File: doc/BRIEF.md
# Register Mapping Table with Speculative and Committed Copies

This block holds the mapping from 32 logical registers to physical registers for an out-of-order core. It keeps two copies of the mapping. The speculative copy is read and written by the rename stage. The committed copy changes only when instructions retire. Each rename slot reads one entry per source operand. It also reads one more entry, addressed by the slot's logical destination, which gives the physical register that the destination held before. That register is freed later.

Each speculative write port is shared by a rename slot and a commit lane. A rename slot writes its newly allocated physical register. For an eliminated move it writes the move's source physical register instead. During a walk after a mispredict, each walked lane rolls its logical destination back to the old physical register. Commit lanes beyond the rename width carry only walk writes. A flush copies the whole committed table into the speculative one. The committed table is also driven in full on a debug output.

Top module: `rename_map_table`

## Requirements
- R1: After reset, entry j of both tables holds physical register j.
- R2: Read port k of slot s (flat index s*(NUM_SRC+1)+k, where k=NUM_SRC is the destination port) combinationally returns the speculative entry as it stood at the start of the cycle. A write made in the same cycle is not bypassed to it.
- R3: When renWen[i] is high and neither walkEn nor redirect is high, the speculative entry renLdest[i] becomes renPdest[i] on the next edge. If renMoveElim[i] is also high, it becomes renMovePsrc[i] instead.
- R4: When walkEn and cmtValid[i] are high, the speculative entry cmtLdest[i] becomes cmtOldPdest[i]. Rename writes are ignored in that cycle, and the committed table does not change.
- R5: When cmtValid[i] is high and walkEn is low, the committed entry cmtLdest[i] becomes cmtPdest[i]. The speculative table is not touched by this write.
- R6: When several ports of one table write the same logical register in one cycle, the port with the highest index wins. Rename write i and commit lane i share index i.
- R7: When flush is high, every speculative entry takes the value its committed entry held at the start of the cycle. This overrides all speculative writes of that cycle. Commit writes to the committed table still apply.
- R8: When redirect is high, rename writes are ignored. Walk and commit writes are unaffected.
- R9: dbgArch bits [j*PW +: PW] carry committed entry j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore speculative table from committed table |
| redirect | input | 1 | Suppress rename writes this cycle |
| walkEn | input | 1 | Commit lanes carry walk (rollback) entries |
| rdAddr | input | RENAME_W*(NUM_SRC+1)*LW | Logical read addresses, per slot |
| rdData | output | RENAME_W*(NUM_SRC+1)*PW | Speculative mapping for each read address |
| renWen | input | RENAME_W | Rename write enable per slot |
| renLdest | input | RENAME_W*LW | Rename logical destination |
| renPdest | input | RENAME_W*PW | Newly allocated physical register |
| renMoveElim | input | RENAME_W | Slot is an eliminated move |
| renMovePsrc | input | RENAME_W*PW | Source physical register of the move |
| cmtValid | input | COMMIT_W | Commit/walk lane valid with a destination |
| cmtLdest | input | COMMIT_W*LW | Lane logical destination |
| cmtPdest | input | COMMIT_W*PW | Lane physical destination |
| cmtOldPdest | input | COMMIT_W*PW | Lane previous physical destination |
| dbgArch | output | NUM_LREG*PW | Whole committed table |

## Verification
The assertions check on every cycle that a flush leaves the speculative table equal to the committed table that preceded it. They also check that the highest walk lane and the highest commit lane land their data, that a walk leaves the committed table unchanged, and that redirect or an idle cycle leaves the speculative table unchanged. Only the bench's scenarios show the reset mapping, the absence of a same-cycle bypass on reads, eliminated-move data selection, and port priority among colliding writes. The same goes for the full per-entry contents compared against a model over thousands of mixed cycles.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;
  typedef struct packed {
    logic copyArch;    // bulk restore speculative from committed
    logic walkActive;  // commit lanes are rollback writes
    logic renameOk;    // rename writes may land this cycle
  } mapStrobes_t;
endpackage

// File: rtl/rename_map_ctrl.sv
module rename_map_ctrl
  import rename_map_pkg::*;
#(
  parameter int RENAME_W = 2,
  parameter int COMMIT_W = 3,
  parameter int LW = 5,
  parameter int PW = 6
) (
  input  logic                   flush,
  input  logic                   redirect,
  input  logic                   walkEn,
  input  logic [RENAME_W-1:0]    renWen,
  input  logic [RENAME_W*LW-1:0] renLdest,
  input  logic [RENAME_W*PW-1:0] renPdest,
  input  logic [RENAME_W-1:0]    renMoveElim,
  input  logic [RENAME_W*PW-1:0] renMovePsrc,
  input  logic [COMMIT_W-1:0]    cmtValid,
  input  logic [COMMIT_W*LW-1:0] cmtLdest,
  input  logic [COMMIT_W*PW-1:0] cmtPdest,
  input  logic [COMMIT_W*PW-1:0] cmtOldPdest,
  output mapStrobes_t            strobes,
  output logic [COMMIT_W-1:0]    specWe,
  output logic [COMMIT_W*LW-1:0] specWa,
  output logic [COMMIT_W*PW-1:0] specWd,
  output logic [COMMIT_W-1:0]    archWe,
  output logic [COMMIT_W*LW-1:0] archWa,
  output logic [COMMIT_W*PW-1:0] archWd
);
  always_comb begin
    strobes.copyArch   = flush;
    strobes.walkActive = walkEn;
    strobes.renameOk   = !walkEn && !redirect;
  end

  for (genvar i = 0; i < COMMIT_W; i++) begin : g_port
    logic walkHit;
    assign walkHit = walkEn && cmtValid[i];

    assign archWe[i]             = cmtValid[i] && !walkEn;
    assign archWa[i*LW +: LW]    = cmtLdest[i*LW +: LW];
    assign archWd[i*PW +: PW]    = cmtPdest[i*PW +: PW];

    if (i < RENAME_W) begin : g_shared
      logic renHit;
      logic [PW-1:0] renData;
      assign renHit  = renWen[i] && !walkEn && !redirect;
      assign renData = renMoveElim[i] ? renMovePsrc[i*PW +: PW] : renPdest[i*PW +: PW];
      assign specWe[i]          = renHit || walkHit;
      assign specWa[i*LW +: LW] = renHit ? renLdest[i*LW +: LW] : cmtLdest[i*LW +: LW];
      assign specWd[i*PW +: PW] = renHit ? renData : cmtOldPdest[i*PW +: PW];
    end else begin : g_walkOnly
      assign specWe[i]          = walkHit;
      assign specWa[i*LW +: LW] = cmtLdest[i*LW +: LW];
      assign specWd[i*PW +: PW] = cmtOldPdest[i*PW +: PW];
    end
  end
endmodule

// File: rtl/rename_map_dp.sv
module rename_map_dp
  import rename_map_pkg::*;
#(
  parameter int NUM_LREG = 32,
  parameter int COMMIT_W = 3,
  parameter int NUM_RD = 8,
  parameter int LW = 5,
  parameter int PW = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mapStrobes_t            strobes,
  input  logic [COMMIT_W-1:0]    specWe,
  input  logic [COMMIT_W*LW-1:0] specWa,
  input  logic [COMMIT_W*PW-1:0] specWd,
  input  logic [COMMIT_W-1:0]    archWe,
  input  logic [COMMIT_W*LW-1:0] archWa,
  input  logic [COMMIT_W*PW-1:0] archWd,
  input  logic [NUM_RD*LW-1:0]   rdAddr,
  output logic [NUM_RD*PW-1:0]   rdData,
  output logic [NUM_LREG*PW-1:0] specFlat,
  output logic [NUM_LREG*PW-1:0] archFlat
);
  logic [PW-1:0] specTab [NUM_LREG];
  logic [PW-1:0] archTab [NUM_LREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < NUM_LREG; j++) begin
        specTab[j] <= PW'(j);
        archTab[j] <= PW'(j);
      end
    end else begin
      if (strobes.copyArch) begin
        for (int j = 0; j < NUM_LREG; j++) specTab[j] <= archTab[j];
      end else begin
        for (int i = 0; i < COMMIT_W; i++)
          if (specWe[i]) specTab[specWa[i*LW +: LW]] <= specWd[i*PW +: PW];
      end
      for (int i = 0; i < COMMIT_W; i++)
        if (archWe[i]) archTab[archWa[i*LW +: LW]] <= archWd[i*PW +: PW];
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rdData[k*PW +: PW] = specTab[rdAddr[k*LW +: LW]];
  end

  for (genvar j = 0; j < NUM_LREG; j++) begin : g_flat
    assign specFlat[j*PW +: PW] = specTab[j];
    assign archFlat[j*PW +: PW] = archTab[j];
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_map_pkg::*;
#(
  parameter int NUM_LREG = 32,
  parameter int NUM_PREG = 64,
  parameter int RENAME_W = 2,
  parameter int COMMIT_W = 3,
  parameter int NUM_SRC  = 3,
  localparam int LW = $clog2(NUM_LREG),
  localparam int PW = $clog2(NUM_PREG),
  localparam int RD_PER_SLOT = NUM_SRC + 1,
  localparam int NUM_RD = RENAME_W * RD_PER_SLOT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic                   redirect,
  input  logic                   walkEn,
  input  logic [NUM_RD*LW-1:0]   rdAddr,
  output logic [NUM_RD*PW-1:0]   rdData,
  input  logic [RENAME_W-1:0]    renWen,
  input  logic [RENAME_W*LW-1:0] renLdest,
  input  logic [RENAME_W*PW-1:0] renPdest,
  input  logic [RENAME_W-1:0]    renMoveElim,
  input  logic [RENAME_W*PW-1:0] renMovePsrc,
  input  logic [COMMIT_W-1:0]    cmtValid,
  input  logic [COMMIT_W*LW-1:0] cmtLdest,
  input  logic [COMMIT_W*PW-1:0] cmtPdest,
  input  logic [COMMIT_W*PW-1:0] cmtOldPdest,
  output logic [NUM_LREG*PW-1:0] dbgArch
);
  mapStrobes_t            strobes;
  logic [COMMIT_W-1:0]    specWe, archWe;
  logic [COMMIT_W*LW-1:0] specWa, archWa;
  logic [COMMIT_W*PW-1:0] specWd, archWd;
  logic [NUM_LREG*PW-1:0] specFlat;

  rename_map_ctrl #(.RENAME_W(RENAME_W), .COMMIT_W(COMMIT_W), .LW(LW), .PW(PW)) u_ctrl (
    .flush(flush), .redirect(redirect), .walkEn(walkEn),
    .renWen(renWen), .renLdest(renLdest), .renPdest(renPdest),
    .renMoveElim(renMoveElim), .renMovePsrc(renMovePsrc),
    .cmtValid(cmtValid), .cmtLdest(cmtLdest), .cmtPdest(cmtPdest), .cmtOldPdest(cmtOldPdest),
    .strobes(strobes), .specWe(specWe), .specWa(specWa), .specWd(specWd),
    .archWe(archWe), .archWa(archWa), .archWd(archWd)
  );

  rename_map_dp #(.NUM_LREG(NUM_LREG), .COMMIT_W(COMMIT_W), .NUM_RD(NUM_RD), .LW(LW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .specWe(specWe), .specWa(specWa), .specWd(specWd),
    .archWe(archWe), .archWa(archWa), .archWd(archWd),
    .rdAddr(rdAddr), .rdData(rdData), .specFlat(specFlat), .archFlat(dbgArch)
  );
endmodule

// File: rtl/rename_map_checker.sv
module rename_map_checker #(
  parameter int NUM_LREG = 32,
  parameter int RENAME_W = 2,
  parameter int COMMIT_W = 3,
  parameter int LW = 5,
  parameter int PW = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic                   redirect,
  input logic                   walkEn,
  input logic [RENAME_W-1:0]    renWen,
  input logic [COMMIT_W-1:0]    cmtValid,
  input logic [COMMIT_W*LW-1:0] cmtLdest,
  input logic [COMMIT_W*PW-1:0] cmtPdest,
  input logic [COMMIT_W*PW-1:0] cmtOldPdest,
  input logic [NUM_LREG*PW-1:0] specMap,
  input logic [NUM_LREG*PW-1:0] archMap
);
  localparam int TOP = COMMIT_W - 1;

  function automatic logic [PW-1:0] ent(input logic [NUM_LREG*PW-1:0] t, input logic [LW-1:0] a);
    return t[a*PW +: PW];
  endfunction

  p_flush_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> specMap == $past(archMap));

  p_arch_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid[TOP] && !walkEn) |=> ent(archMap, $past(cmtLdest[TOP*LW +: LW])) == $past(cmtPdest[TOP*PW +: PW]));

  p_walk_keeps_arch_r4: assert property (@(posedge clk) disable iff (!rstN)
    walkEn |=> archMap == $past(archMap));

  if (COMMIT_W > RENAME_W) begin : g_walkTop
    p_walk_rollback_r4: assert property (@(posedge clk) disable iff (!rstN)
      (walkEn && cmtValid[TOP] && !flush) |=> ent(specMap, $past(cmtLdest[TOP*LW +: LW])) == $past(cmtOldPdest[TOP*PW +: PW]));
  end

  p_redirect_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !walkEn && !flush) |=> specMap == $past(specMap));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !walkEn && renWen == '0) |=> $stable(specMap));
endmodule

bind rename_map_table rename_map_checker #(
  .NUM_LREG(NUM_LREG), .RENAME_W(RENAME_W), .COMMIT_W(COMMIT_W), .LW(LW), .PW(PW)
) u_checker (
  .clk(clk), .rstN(rstN), .flush(flush), .redirect(redirect), .walkEn(walkEn),
  .renWen(renWen), .cmtValid(cmtValid), .cmtLdest(cmtLdest), .cmtPdest(cmtPdest),
  .cmtOldPdest(cmtOldPdest), .specMap(specFlat), .archMap(dbgArch)
);

// File: tb/rename_map_table_tb.sv
module rename_map_table_tb;
  localparam int NL = 32, R = 2, C = 3, S = 3, LW = 5, PW = 6, NRD = R * (S + 1);

  logic clk = 0, rstN = 0;
  logic flush = 0, redirect = 0, walkEn = 0;
  logic [NRD*LW-1:0] rdAddr = '0;
  logic [NRD*PW-1:0] rdData;
  logic [R-1:0] renWen = '0, renMoveElim = '0;
  logic [R*LW-1:0] renLdest = '0;
  logic [R*PW-1:0] renPdest = '0, renMovePsrc = '0;
  logic [C-1:0] cmtValid = '0;
  logic [C*LW-1:0] cmtLdest = '0;
  logic [C*PW-1:0] cmtPdest = '0, cmtOldPdest = '0;
  logic [NL*PW-1:0] dbgArch;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  string tag = "R1";
  int specM [NL];
  int archM [NL];

  always #2.5 clk = ~clk;

  rename_map_table u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .redirect(redirect), .walkEn(walkEn),
    .rdAddr(rdAddr), .rdData(rdData), .renWen(renWen), .renLdest(renLdest),
    .renPdest(renPdest), .renMoveElim(renMoveElim), .renMovePsrc(renMovePsrc),
    .cmtValid(cmtValid), .cmtLdest(cmtLdest), .cmtPdest(cmtPdest),
    .cmtOldPdest(cmtOldPdest), .dbgArch(dbgArch)
  );

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic checkOutputs();
    for (int k = 0; k < NRD; k++) begin
      int a = int'(rdAddr[k*LW +: LW]);
      chk(int'(rdData[k*PW +: PW]) == specM[a], tag, int'(rdData[k*PW +: PW]), specM[a]);
    end
    for (int j = 0; j < NL; j++)
      chk(int'(dbgArch[j*PW +: PW]) == archM[j], "R9", int'(dbgArch[j*PW +: PW]), archM[j]);
  endtask

  task automatic updateModel();
    int ns [NL];
    for (int j = 0; j < NL; j++) ns[j] = specM[j];
    for (int i = 0; i < C; i++) begin
      if (i < R && renWen[i] && !walkEn && !redirect)
        ns[renLdest[i*LW +: LW]] = renMoveElim[i] ? int'(renMovePsrc[i*PW +: PW]) : int'(renPdest[i*PW +: PW]);
      else if (walkEn && cmtValid[i])
        ns[cmtLdest[i*LW +: LW]] = int'(cmtOldPdest[i*PW +: PW]);
    end
    if (flush) for (int j = 0; j < NL; j++) ns[j] = archM[j];
    for (int i = 0; i < C; i++)
      if (!walkEn && cmtValid[i]) archM[cmtLdest[i*LW +: LW]] = int'(cmtPdest[i*PW +: PW]);
    for (int j = 0; j < NL; j++) specM[j] = ns[j];
  endtask

  // Called at a negative edge with inputs set; checks, clocks, updates the model.
  task automatic step();
    #1;
    checkOutputs();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; redirect = 0; walkEn = 0; renWen = '0; renMoveElim = '0; cmtValid = '0;
  endtask

  task automatic randReads();
    for (int k = 0; k < NRD; k++) rdAddr[k*LW +: LW] = LW'($urandom);
  endtask

  task automatic readSweep();
    for (int b = 0; b < NL; b += NRD) begin
      for (int k = 0; k < NRD; k++) rdAddr[k*LW +: LW] = LW'(b + k);
      step();
    end
  endtask

  initial begin
    for (int j = 0; j < NL; j++) begin specM[j] = j; archM[j] = j; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: identity after reset, every entry of both tables
    tag = "R1"; readSweep();

    // R3: plain rename write and eliminated-move write
    tag = "R3";
    renWen = 2'b11; renLdest = {5'd6, 5'd5}; renPdest = {6'd50, 6'd40};
    renMoveElim = 2'b10; renMovePsrc = {6'd33, 6'd0};
    step(); idle(); readSweep();

    // R2: write and read the same entry in one cycle -> old value seen
    tag = "R2";
    renWen = 2'b01; renLdest = {5'd0, 5'd7}; renPdest = {6'd0, 6'd61};
    for (int k = 0; k < NRD; k++) rdAddr[k*LW +: LW] = 5'd7;
    step(); idle(); step();

    // R8: redirect suppresses rename writes
    tag = "R8";
    redirect = 1; renWen = 2'b11; renLdest = {5'd9, 5'd8}; renPdest = {6'd44, 6'd45};
    step(); idle(); readSweep();

    // R5: commit writes the committed table only
    tag = "R5";
    cmtValid = 3'b111; cmtLdest = {5'd3, 5'd2, 5'd1}; cmtPdest = {6'd63, 6'd62, 6'd60};
    step(); idle(); readSweep();

    // R4: walk rolls back speculative entries; rename and committed table untouched
    tag = "R4";
    walkEn = 1; cmtValid = 3'b111; cmtLdest = {5'd5, 5'd6, 5'd7};
    cmtOldPdest = {6'd11, 6'd12, 6'd13}; cmtPdest = {6'd20, 6'd21, 6'd22};
    renWen = 2'b11; renLdest = {5'd1, 5'd2}; renPdest = {6'd55, 6'd56};
    step(); idle(); readSweep();

    // R6: same-address collisions, highest port wins
    tag = "R6";
    renWen = 2'b11; renLdest = {5'd10, 5'd10}; renPdest = {6'd31, 6'd30};
    cmtValid = 3'b111; cmtLdest = {5'd4, 5'd4, 5'd4}; cmtPdest = {6'd27, 6'd26, 6'd25};
    step(); idle();
    walkEn = 1; cmtValid = 3'b111; cmtLdest = {5'd12, 5'd12, 5'd12}; cmtOldPdest = {6'd3, 6'd2, 6'd1};
    step(); idle(); readSweep();

    // R7: flush restores from committed, overriding concurrent rename writes
    tag = "R7";
    flush = 1; renWen = 2'b11; renLdest = {5'd4, 5'd10}; renPdest = {6'd14, 6'd15};
    cmtValid = 3'b001; cmtLdest = {5'd0, 5'd0, 5'd4}; cmtPdest = {6'd0, 6'd0, 6'd17};
    step(); idle(); readSweep();

    // Mixed sweep: all modes with a narrow address range to force collisions
    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      int mode = $urandom_range(0, 9);
      randReads();
      flush = (mode == 0); redirect = (mode == 1); walkEn = (mode >= 7);
      renWen = R'($urandom); renMoveElim = R'($urandom);
      cmtValid = C'($urandom);
      for (int i = 0; i < R; i++) begin
        renLdest[i*LW +: LW] = LW'($urandom_range(0, 7));
        renPdest[i*PW +: PW] = PW'($urandom);
        renMovePsrc[i*PW +: PW] = PW'($urandom);
      end
      for (int i = 0; i < C; i++) begin
        cmtLdest[i*LW +: LW] = LW'($urandom_range(0, 7));
        cmtPdest[i*PW +: PW] = PW'($urandom);
        cmtOldPdest[i*PW +: PW] = PW'($urandom);
      end
      step();
    end
    idle(); tag = "R3"; readSweep();

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule